// File: doc/BRIEF.md
# Latency-Balancing Hit Request Dispatcher

This block sits in front of two memory request queues: one for a die-stacked DRAM cache and one for off-chip DRAM. For every incoming request it picks one of the two queues. A request to a region that may hold modified data must be served by the cache. A clean request that the hit predictor expects to miss goes straight to off-chip memory. A clean request that is expected to hit can be served by either memory, so the block sends it to whichever one should answer first.

The expected wait at each memory is the occupancy of the target bank's queue times that memory's configured base (unqueued) access latency. Off-chip memory wins only when its estimate is strictly lower. Each memory finds its bank in its own address field, set by parameters. The block takes occupancy counts and base latencies as inputs. The decision is registered in a single holding slot and offered to the chosen queue with a valid/ready handshake. The slot frees in the same cycle it drains, so the block can accept one request per cycle.

Top module: `hit_dispatch_router`

## Requirements
- R1: After a synchronous active-low reset, both `cache_valid` and `mem_valid` are 0 and `req_ready` is 1.
- R2: An accepted request with `req_dirty`=1 is routed to the cache (`cache_valid`=1, `mem_valid`=0), whatever its prediction and the occupancies.
- R3: An accepted request with `req_dirty`=0 and `req_pred_hit`=0 is routed off-chip (`mem_valid`=1).
- R4: For a clean request with `req_pred_hit`=1, if mem_occ[bank_m] × `mem_base_lat` < cache_occ[bank_c] × `cache_base_lat`, the request goes off-chip.
- R5: For a clean request with `req_pred_hit`=1, if the off-chip product is greater than or equal to the cache product (ties included), the request goes to the cache.
- R6: bank_c is `req_addr[CBANK_LSB +: CBANK_BITS]` (default bits 8:6) and bank_m is `req_addr[MBANK_LSB +: MBANK_BITS]` (default bits 15:13). Occupancy of bank b is the field `[b*OCC_W +: OCC_W]` of the matching packed occupancy vector.
- R7: The products are compared at their full width of OCC_W+LAT_W bits. With maximum occupancy and latencies near the top of their range, the comparison is still exact.
- R8: A request accepted at a clock edge is presented at the outputs from that edge on, with `out_addr` equal to the accepted `req_addr`.
- R9: While the presented request's destination has its ready low, the request stays presented with unchanged route and address, and `req_ready` is 0.
- R10: `cache_valid` and `mem_valid` are never 1 together.
- R11: When the presented request drains (its destination ready is 1), `req_ready` is 1 in that same cycle, and a new request can be accepted at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | ADDR_W | Request address |
| req_dirty | input | 1 | Request targets a write-back (dirty) region |
| req_pred_hit | input | 1 | Predictor expects a cache hit |
| cache_occ | input | 2^CBANK_BITS × OCC_W | Packed per-bank cache queue occupancy |
| mem_occ | input | 2^MBANK_BITS × OCC_W | Packed per-bank off-chip queue occupancy |
| cache_base_lat | input | LAT_W | Base access latency of the cache |
| mem_base_lat | input | LAT_W | Base access latency of off-chip memory |
| cache_valid | output | 1 | Presented request is for the cache queue |
| cache_ready | input | 1 | Cache queue accepts |
| mem_valid | output | 1 | Presented request is for the off-chip queue |
| mem_ready | input | 1 | Off-chip queue accepts |
| out_addr | output | ADDR_W | Address of the presented request |

## Verification
The bench targets equal estimates. A design that used a non-strict comparison would send those hit requests off-chip. It drives saturated occupancies with latencies close together, where products truncated to a narrow width would reverse the choice. It gives the two address fields different banks with very different occupancies, which catches a design that reads the wrong field or the wrong slot. It also holds back the chosen destination while the other queue is ready. A stage that dropped or overwrote the held request, or that drained on the wrong ready, would show a changed address or a wrong `req_ready`.

// File: rtl/hdr_pkg.sv
// Package: shared types for the hit request dispatcher.
// Assumes: nothing beyond a two-way route choice.
package hdr_pkg;
    typedef enum logic {
        DEST_CACHE = 1'b0,
        DEST_MEM   = 1'b1
    } dest_e;
endpackage

// File: rtl/hdr_bank_cost.sv
// Module: hdr_bank_cost
// Selects the occupancy of one bank from a packed per-bank vector and
// multiplies it by a base latency to give the expected wait.
// Assumes: the caller slices the bank field out of the address; the
// product is formed at OCC_W+LAT_W bits so it cannot overflow.
module hdr_bank_cost #(
    parameter int FLD_BITS = 3,
    parameter int OCC_W    = 6,
    parameter int LAT_W    = 8
) (
    input  logic [FLD_BITS-1:0]               bank,
    input  logic [(1<<FLD_BITS)*OCC_W-1:0]    occ_flat,
    input  logic [LAT_W-1:0]                  base_lat,
    output logic [OCC_W+LAT_W-1:0]            cost
);
    localparam int NBANK  = 1 << FLD_BITS;
    localparam int COST_W = OCC_W + LAT_W;

    logic [OCC_W-1:0] occ_arr [NBANK];

    // Unpack the per-bank occupancy fields.
    for (genvar g = 0; g < NBANK; g++) begin : g_unpack
        assign occ_arr[g] = occ_flat[g*OCC_W +: OCC_W];
    end

    // Expected latency: selected depth times base latency, full width.
    always_comb begin
        cost = COST_W'(occ_arr[bank]) * COST_W'(base_lat);
    end
endmodule

// File: rtl/hdr_route_pick.sv
// Module: hdr_route_pick
// Chooses a destination from the dirty flag, the prediction and the two
// expected latencies. Off-chip wins a clean predicted hit only when
// strictly faster.
// Assumes: both costs share one width.
module hdr_route_pick
    import hdr_pkg::*;
#(
    parameter int COST_W = 14
) (
    input  logic              dirty,
    input  logic              pred_hit,
    input  logic [COST_W-1:0] cost_cache,
    input  logic [COST_W-1:0] cost_mem,
    output dest_e             dest
);
    // Priority: dirty region, then predicted miss, then balancing.
    always_comb begin
        if (dirty)                   dest = DEST_CACHE;
        else if (!pred_hit)          dest = DEST_MEM;
        else if (cost_mem < cost_cache) dest = DEST_MEM;
        else                         dest = DEST_CACHE;
    end
endmodule

// File: rtl/hdr_hold_stage.sv
// Module: hdr_hold_stage
// One-entry registered slot holding a routed request and presenting it to
// the chosen queue. Refills in the cycle it drains.
// Assumes: downstream ready may depend on nothing from this block.
module hdr_hold_stage
    import hdr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  dest_e             in_dest,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              cache_valid,
    input  logic              cache_ready,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] out_addr
);
    logic              held_v;
    dest_e             held_dest;
    logic [ADDR_W-1:0] held_addr;
    logic              drain;

    // Drain when the held entry's own destination accepts it.
    always_comb begin
        drain    = held_v && ((held_dest == DEST_MEM) ? mem_ready : cache_ready);
        in_ready = !held_v || drain;
    end

    // Load a new entry whenever the slot is free or freeing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v    <= 1'b0;
            held_dest <= DEST_CACHE;
            held_addr <= '0;
        end else if (in_ready) begin
            held_v <= in_valid;
            if (in_valid) begin
                held_dest <= in_dest;
                held_addr <= in_addr;
            end
        end
    end

    // Present the held entry on the selected side only.
    always_comb begin
        cache_valid = held_v && (held_dest == DEST_CACHE);
        mem_valid   = held_v && (held_dest == DEST_MEM);
        out_addr    = held_addr;
    end

    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cache_valid, mem_valid}));

    assert_hold_cache_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_valid && !cache_ready) |=> (cache_valid && $stable(out_addr)));

    assert_hold_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(out_addr)));
endmodule

// File: rtl/hit_dispatch_router.sv
// Module: hit_dispatch_router (top)
// Routes each request to the DRAM cache queue or the off-chip queue.
// Dirty-region requests go to the cache, predicted misses go off-chip, and
// clean predicted hits go to the memory with the lower expected latency
// (bank queue depth times base latency; ties favour the cache).
// Assumes: occupancy counts and base latencies come from outside and are
// sampled in the cycle the request is accepted.
module hit_dispatch_router
    import hdr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CBANK_LSB  = 6,
    parameter int CBANK_BITS = 3,
    parameter int MBANK_LSB  = 13,
    parameter int MBANK_BITS = 3,
    parameter int OCC_W      = 6,
    parameter int LAT_W      = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic                              req_dirty,
    input  logic                              req_pred_hit,
    input  logic [(1<<CBANK_BITS)*OCC_W-1:0]  cache_occ,
    input  logic [(1<<MBANK_BITS)*OCC_W-1:0]  mem_occ,
    input  logic [LAT_W-1:0]                  cache_base_lat,
    input  logic [LAT_W-1:0]                  mem_base_lat,
    output logic                              cache_valid,
    input  logic                              cache_ready,
    output logic                              mem_valid,
    input  logic                              mem_ready,
    output logic [ADDR_W-1:0]                 out_addr
);
    localparam int COST_W = OCC_W + LAT_W;

    logic [CBANK_BITS-1:0] bank_c;
    logic [MBANK_BITS-1:0] bank_m;
    logic [COST_W-1:0]     cost_c;
    logic [COST_W-1:0]     cost_m;
    dest_e                 dest;

    // Extract each memory's bank field from the address.
    always_comb begin
        bank_c = req_addr[CBANK_LSB +: CBANK_BITS];
        bank_m = req_addr[MBANK_LSB +: MBANK_BITS];
    end

    hdr_bank_cost #(.FLD_BITS(CBANK_BITS), .OCC_W(OCC_W), .LAT_W(LAT_W)) u_cost_cache (
        .bank(bank_c), .occ_flat(cache_occ), .base_lat(cache_base_lat), .cost(cost_c));

    hdr_bank_cost #(.FLD_BITS(MBANK_BITS), .OCC_W(OCC_W), .LAT_W(LAT_W)) u_cost_mem (
        .bank(bank_m), .occ_flat(mem_occ), .base_lat(mem_base_lat), .cost(cost_m));

    hdr_route_pick #(.COST_W(COST_W)) u_pick (
        .dirty(req_dirty), .pred_hit(req_pred_hit),
        .cost_cache(cost_c), .cost_mem(cost_m), .dest(dest));

    hdr_hold_stage #(.ADDR_W(ADDR_W)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .in_valid(req_valid), .in_ready(req_ready),
        .in_dest(dest), .in_addr(req_addr),
        .cache_valid(cache_valid), .cache_ready(cache_ready),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .out_addr(out_addr));

    assert_dirty_cache_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_dirty) |=> (cache_valid && !mem_valid));

    assert_miss_offchip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_dirty && !req_pred_hit) |=> mem_valid);

    assert_addr_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (out_addr == $past(req_addr)));
endmodule

// File: tb/hit_dispatch_router_bench.sv
module hit_dispatch_router_bench;
    localparam int AW = 32, CL = 6, CB = 3, ML = 13, MB = 3, OW = 6, LW = 8;
    localparam int NC = 1 << CB, NM = 1 << MB;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, req_valid, req_dirty, req_pred_hit, cache_ready, mem_ready;
    logic [AW-1:0] req_addr;
    logic [NC*OW-1:0] cache_occ;
    logic [NM*OW-1:0] mem_occ;
    logic [LW-1:0] cache_base_lat, mem_base_lat;
    logic req_ready, cache_valid, mem_valid;
    logic [AW-1:0] out_addr;

    hit_dispatch_router u_hit_dispatch_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_dirty(req_dirty), .req_pred_hit(req_pred_hit),
        .cache_occ(cache_occ), .mem_occ(mem_occ),
        .cache_base_lat(cache_base_lat), .mem_base_lat(mem_base_lat),
        .cache_valid(cache_valid), .cache_ready(cache_ready),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .out_addr(out_addr));

    // staged stimulus, applied at the falling edge
    logic t_rst_n, t_valid, t_dirty, t_hit, t_crdy, t_mrdy;
    logic [AW-1:0] t_addr;
    logic [NC*OW-1:0] t_cocc;
    logic [NM*OW-1:0] t_mocc;
    logic [LW-1:0] t_clat, t_mlat;
    string t_tag;

    // reference model state
    bit m_known = 0, m_v = 0, m_mem = 0;
    logic [AW-1:0] m_addr;
    string m_tag = "";

    int checks = 0, errors = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        bit drain, rdy;
        int bc, bm, ec, em;
        @(negedge clk);
        rst_n = t_rst_n; req_valid = t_valid; req_addr = t_addr; req_dirty = t_dirty;
        req_pred_hit = t_hit; cache_occ = t_cocc; mem_occ = t_mocc;
        cache_base_lat = t_clat; mem_base_lat = t_mlat; cache_ready = t_crdy; mem_ready = t_mrdy;
        #1;
        drain = m_v && (m_mem ? t_mrdy : t_crdy);
        rdy = !m_v || drain;
        if (m_known) begin
            chk(cache_valid == (m_v && !m_mem), m_v ? m_tag : "R1", "cache_valid", cache_valid, m_v && !m_mem);
            chk(mem_valid == (m_v && m_mem), m_v ? m_tag : "R1", "mem_valid", mem_valid, m_v && m_mem);
            chk(!(cache_valid && mem_valid), "R10", "both valid", 1, 0);
            if (m_v) chk(out_addr == m_addr, "R8", "out_addr", out_addr, m_addr);
            chk(req_ready == rdy, (m_v && !drain) ? "R9" : "R11", "req_ready", req_ready, rdy);
        end
        // model the coming rising edge
        if (!t_rst_n) begin
            m_known = 1; m_v = 0;
        end else if (m_known && rdy) begin
            m_v = t_valid;
            if (t_valid) begin
                bc = int'(t_addr[CL +: CB]);
                bm = int'(t_addr[ML +: MB]);
                ec = int'(t_cocc[bc*OW +: OW]) * int'(t_clat);
                em = int'(t_mocc[bm*OW +: OW]) * int'(t_mlat);
                m_addr = t_addr;
                if (t_dirty)        begin m_mem = 0; m_tag = "R2"; end
                else if (!t_hit)    begin m_mem = 1; m_tag = "R3"; end
                else if (em < ec)   begin m_mem = 1; m_tag = "R4"; end
                else                begin m_mem = 0; m_tag = "R5"; end
                if (t_tag != "") m_tag = t_tag;
            end
        end
    endtask

    task automatic set_occ(bit mem_side, int bank, int val);
        if (mem_side) t_mocc[bank*OW +: OW] = OW'(val);
        else          t_cocc[bank*OW +: OW] = OW'(val);
    endtask

    function automatic logic [AW-1:0] mk_addr(int bc, int bm);
        logic [AW-1:0] a = 32'h0100_0000;
        a[CL +: CB] = CB'(bc);
        a[ML +: MB] = MB'(bm);
        return a;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_rst_n = 0; t_valid = 0; t_dirty = 0; t_hit = 0; t_crdy = 1; t_mrdy = 1;
        t_addr = '0; t_cocc = '0; t_mocc = '0; t_clat = 8'd20; t_mlat = 8'd40; t_tag = "";
        repeat (3) step();
        t_rst_n = 1;
        step();
        // R1: reset state seen at ports
        chk(!cache_valid && !mem_valid && req_ready, "R1", "reset outputs", {cache_valid, mem_valid, req_ready}, 3'b001);

        // R2: dirty goes to cache even when off-chip is idle
        set_occ(0, 2, 50); t_addr = mk_addr(2, 0); t_valid = 1; t_dirty = 1; t_hit = 1; step();
        t_hit = 0; step();
        // R3: clean predicted miss goes off-chip even if cache is idle
        t_cocc = '0; set_occ(1, 0, 60); t_dirty = 0; t_hit = 0; step();
        // R4 / R5: tie and strict cases
        t_cocc = '0; t_mocc = '0; t_hit = 1;
        t_clat = 8'd20; t_mlat = 8'd40;
        set_occ(0, 1, 4); set_occ(1, 5, 2); t_addr = mk_addr(1, 5); t_tag = "R5"; step(); // 80 vs 80 tie
        set_occ(1, 5, 1); t_tag = "R4"; step();                                         // 40 < 80
        // R6: other bank slots hold decoys
        t_cocc = '0; t_mocc = '0;
        set_occ(0, 6, 10); set_occ(1, 3, 1); set_occ(1, 6, 63); set_occ(0, 3, 0);
        t_addr = mk_addr(6, 3); t_tag = "R6"; step();  // 40 < 200 -> off-chip
        t_addr = mk_addr(3, 6); step();                // 2520 >= 0 -> cache
        // R7: wide products
        t_cocc = {NC{6'd63}}; t_mocc = {NM{6'd63}};
        t_clat = 8'd255; t_mlat = 8'd254; t_tag = "R7"; t_addr = mk_addr(7, 7); step();
        t_clat = 8'd254; t_mlat = 8'd255; step();
        t_tag = "";
        // R9: stall the destination while the other side is ready
        t_clat = 8'd10; t_mlat = 8'd10; t_cocc = '0; t_mocc = '0;
        t_dirty = 1; t_crdy = 0; t_mrdy = 1; t_addr = 32'h0000_1234; step();
        t_addr = 32'h0000_5678; repeat (3) step();
        t_crdy = 1; step(); // R11: drains and refills in one cycle
        t_valid = 0; step(); step();

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            t_valid = ($urandom_range(0, 3) != 0);
            t_addr = $urandom();
            t_dirty = ($urandom_range(0, 4) == 0);
            t_hit = ($urandom_range(0, 3) != 0);
            for (int b = 0; b < NC; b++) set_occ(0, b, ($urandom_range(0, 7) == 0) ? 63 : $urandom_range(0, 12));
            for (int b = 0; b < NM; b++) set_occ(1, b, ($urandom_range(0, 7) == 0) ? 63 : $urandom_range(0, 12));
            if ($urandom_range(0, 15) == 0) begin
                t_clat = 8'($urandom()); t_mlat = 8'($urandom());
            end
            t_crdy = ($urandom_range(0, 3) != 0);
            t_mrdy = ($urandom_range(0, 3) != 0);
            step();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule